// File: doc/BRIEF.md
# Rename Group Flow Controller

This block decides, cycle by cycle, which slots of an incoming decode group may pass through rename. It reads a group of up to `WIDTH` slots and limits how many of them go downstream. The limit comes from three places: the free counts reported by the reorder buffer and the issue queue, the free physical register count, and the flags carried by each slot. For every slot it grants, it raises a per-slot grant. The granted slots are packed into an outgoing group. When the stage cannot finish a group, it asserts a stall toward decode.

The reported downstream free counts lag by the issue-to-rename latency. Each one is therefore reduced by `WIDTH * LAT` before use. The stage may rename only part of a group. In that case the whole group is parked in a small skid buffer, together with the slot where work stopped, and renaming later resumes from that slot. A serializing slot parks the stage in a barrier state, which only a squash from commit clears. A squash overrides everything else: it empties the skid buffer and resets the saved slot.

All outputs are registered. A decision made at one clock edge from the inputs present before that edge becomes visible just after it.

Top module: `rn_group_flow`

## Requirements
- R1: After reset, `stage_state` is 0 (idle), `decode_stall` is 0, `grant` is 0 and `out_size` is 0.
- R2: Each downstream credit is its reported free count minus `WIDTH*LAT` (8 by default). If the smaller of the two credits is zero or negative, nothing is granted, `decode_stall` rises and `stage_state` becomes 2 (blocked).
- R3: If the smaller credit is positive but below the number of slots still pending in the group, only that many slots are consumed. The stage then becomes blocked.
- R4: A slot whose squashed flag is set receives no grant and is never placed in the outgoing group. It still counts as consumed, and renaming carries on with the next slot.
- R5: If the free physical register count, reduced by the destination counts of the slots already granted this cycle, is smaller than the current slot's destination count, that slot and every later slot get no grant, and the stage becomes blocked.
- R6: A slot whose serializing flag is set, together with every later slot, gets no grant. `stage_state` becomes 5 (barrier) and stays there until a squash arrives.
- R7: `out_size` equals the number of grants. `out_src` lists the granted slot indexes in ascending order: output slot j holds its index in bits [2j+1:2j], and unused output slots read 0.
- R8: When renaming resumes from the skid buffer (`stage_state` 3, unblocking), it starts at the slot where the earlier attempt stopped. Once a group completes and the buffer is empty, the stage returns to 1 (running).
- R9: A blocked stage moves to unblocking only when neither downstream stall is set, both credits are positive and the free physical register count is nonzero. Otherwise it stays blocked and grants nothing.
- R10: `cmt_squash` beats every other condition. On the next cycle, `stage_state` is 4 (squashing), nothing is granted and `decode_stall` is 0. Skid contents and the saved slot are discarded, so the next group is renamed from slot 0.
- R11: `decode_stall` is 1 exactly when `stage_state` is blocked, unblocking or barrier.
- R12: While either downstream stall input is set, a cycle that would rename grants nothing and the stage blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_size | input | 3 | Number of slots in the incoming group (0 = none) |
| dec_squashed | input | 4 | Per-slot squashed flags |
| dec_serial | input | 4 | Per-slot serializing flags |
| dec_ndst | input | 8 | Per-slot destination counts, 2 bits per slot |
| rob_free | input | 6 | Free reorder-buffer entries as reported |
| iq_free | input | 6 | Free issue-queue entries as reported |
| preg_free | input | 6 | Free physical registers |
| iew_stall | input | 1 | Stall from the issue stage |
| cmt_stall | input | 1 | Stall from commit |
| cmt_squash | input | 1 | Squash from commit |
| grant | output | 4 | Per-slot rename grants for the group processed |
| out_size | output | 3 | Number of valid slots in the outgoing group |
| out_src | output | 8 | Source slot index of each outgoing slot, 2 bits each |
| decode_stall | output | 1 | Stall toward decode |
| stage_state | output | 3 | Current stage state code |

## Verification
Directed groups are chosen so that a single limit is the binding one each time: a credit that derates to exactly zero, a credit of two against four pending slots, a squashed slot in the middle, a physical register count that runs out after one slot, a serializing slot, and a stall from commit. These separate credit blocking, partial renaming, skipping, register starvation and the barrier. The partial case then resumes and must grant only the slots left over, which distinguishes resuming at the saved slot from restarting at slot 0. Random traffic mixes all of these with squashes arriving in every state. A bench-side model computes the expected state, grants and packing for every cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [2:0] {
        RN_IDLE    = 3'd0,
        RN_RUN     = 3'd1,
        RN_BLOCK   = 3'd2,
        RN_UNBLK   = 3'd3,
        RN_SQUASH  = 3'd4,
        RN_BARRIER = 3'd5
    } rn_state_e;
endpackage

// File: rtl/rn_credit.sv
// Derates the downstream free counts and turns the smaller one into a slot limit.
module rn_credit #(
    parameter int WIDTH = 4,
    parameter int LAT   = 2,
    parameter int CNT_W = 6,
    parameter int SZ_W  = 3
) (
    input  logic [CNT_W-1:0] rob_free,
    input  logic [CNT_W-1:0] iq_free,
    input  logic             iew_stall,
    input  logic             cmt_stall,
    output logic             credit_open,
    output logic [SZ_W-1:0]  lim
);
    localparam int SW     = CNT_W + 2;
    localparam int DERATE = WIDTH * LAT;

    logic signed [SW-1:0] rob_c, iq_c, min_c;
    logic                 nonpos;

    always_comb begin
        rob_c  = signed'(SW'(rob_free)) - signed'(SW'(DERATE));
        iq_c   = signed'(SW'(iq_free)) - signed'(SW'(DERATE));
        min_c  = (rob_c < iq_c) ? rob_c : iq_c;
        nonpos = min_c[SW-1] || (min_c == '0);
        credit_open = !nonpos && !iew_stall && !cmt_stall;
        if (!credit_open) begin
            lim = '0;
        end else if (min_c >= signed'(SW'(WIDTH))) begin
            lim = SZ_W'(WIDTH);
        end else begin
            lim = min_c[SZ_W-1:0];
        end
    end
endmodule

// File: rtl/rn_slot_scan.sv
// Walks the group from the start slot and decides grants, packing and stop point.
module rn_slot_scan #(
    parameter int WIDTH = 4,
    parameter int DST_W = 2,
    parameter int CNT_W = 6,
    parameter int SZ_W  = 3,
    parameter int IDX_W = 2
) (
    input  logic [SZ_W-1:0]        grp_size,
    input  logic [SZ_W-1:0]        start,
    input  logic [WIDTH-1:0]       squashed,
    input  logic [WIDTH-1:0]       serial,
    input  logic [WIDTH*DST_W-1:0] ndst,
    input  logic [SZ_W-1:0]        lim,
    input  logic [CNT_W-1:0]       preg_free,
    output logic [WIDTH-1:0]       grant,
    output logic [SZ_W-1:0]        out_size,
    output logic [WIDTH*IDX_W-1:0] out_src,
    output logic [SZ_W-1:0]        next_off,
    output logic                   blocked,
    output logic                   barrier
);
    int  avail;
    int  off;
    int  cnt;
    int  preg;
    logic stop;

    always_comb begin
        avail   = (grp_size > start) ? int'(grp_size) - int'(start) : 0;
        blocked = 1'b0;
        barrier = 1'b0;
        if (int'(lim) < avail) begin
            avail   = int'(lim);
            blocked = 1'b1;
        end
        off     = int'(start);
        cnt     = 0;
        preg    = int'(preg_free);
        stop    = 1'b0;
        grant   = '0;
        out_src = '0;
        for (int k = 0; k < WIDTH; k++) begin
            if (!stop && avail != 0 && k >= int'(start) && k < int'(grp_size)) begin
                if (squashed[k]) begin
                    off   = off + 1;
                    avail = avail - 1;
                end else if (serial[k]) begin
                    barrier = 1'b1;
                    blocked = 1'b1;
                    stop    = 1'b1;
                end else if (preg < int'(ndst[k*DST_W +: DST_W])) begin
                    blocked = 1'b1;
                    stop    = 1'b1;
                end else begin
                    grant[k] = 1'b1;
                    out_src[cnt*IDX_W +: IDX_W] = IDX_W'(k);
                    cnt   = cnt + 1;
                    preg  = preg - int'(ndst[k*DST_W +: DST_W]);
                    off   = off + 1;
                    avail = avail - 1;
                end
            end
        end
        out_size = SZ_W'(cnt);
        next_off = blocked ? SZ_W'(off) : '0;
    end
endmodule

// File: rtl/rn_skid.sv
// Small FIFO of parked decode groups.
module rn_skid #(
    parameter int DEPTH = 2,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DW-1:0]                din,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          ptr_d, ptr_q;
    logic [DW-1:0] mem [DEPTH];
    logic          do_push, do_pop;

    assign full    = (ptr_q.cnt == CW'(DEPTH));
    assign count   = ptr_q.cnt;
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && (ptr_q.cnt != '0) && !flush;
    assign dout    = mem[ptr_q.rd];

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (do_push) begin
                ptr_d.wr = (ptr_q.wr == PW'(DEPTH-1)) ? '0 : ptr_q.wr + 1'b1;
            end
            if (do_pop) begin
                ptr_d.rd = (ptr_q.rd == PW'(DEPTH-1)) ? '0 : ptr_q.rd + 1'b1;
            end
            ptr_d.cnt = ptr_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (do_push && ptr_q.wr == PW'(i)) mem[i] <= din;
        end
    end
endmodule

// File: rtl/rn_group_flow.sv
// Rename-stage group flow controller: credits, partial groups, skid resume, squash.
module rn_group_flow #(
    parameter int WIDTH      = 4,
    parameter int DST_W      = 2,
    parameter int CNT_W      = 6,
    parameter int LAT        = 2,
    parameter int SKID_DEPTH = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [$clog2(WIDTH+1)-1:0]           dec_size,
    input  logic [WIDTH-1:0]                     dec_squashed,
    input  logic [WIDTH-1:0]                     dec_serial,
    input  logic [WIDTH*DST_W-1:0]               dec_ndst,
    input  logic [CNT_W-1:0]                     rob_free,
    input  logic [CNT_W-1:0]                     iq_free,
    input  logic [CNT_W-1:0]                     preg_free,
    input  logic                                 iew_stall,
    input  logic                                 cmt_stall,
    input  logic                                 cmt_squash,
    output logic [WIDTH-1:0]                     grant,
    output logic [$clog2(WIDTH+1)-1:0]           out_size,
    output logic [WIDTH*$clog2(WIDTH)-1:0]       out_src,
    output logic                                 decode_stall,
    output logic [2:0]                           stage_state
);
    import rn_pkg::*;

    localparam int SZ_W  = $clog2(WIDTH + 1);
    localparam int IDX_W = $clog2(WIDTH);
    localparam int GW    = SZ_W + 2*WIDTH + WIDTH*DST_W;
    localparam int CW    = $clog2(SKID_DEPTH + 1);

    typedef struct packed {
        rn_state_e              state;
        logic [SZ_W-1:0]        off;
        logic [WIDTH-1:0]       grant;
        logic [SZ_W-1:0]        osize;
        logic [WIDTH*IDX_W-1:0] osrc;
        logic                   stall;
    } regs_t;

    regs_t r_d, r_q;

    logic [GW-1:0]          grp_in, skid_head, proc_grp;
    logic                   skid_push, skid_pop, skid_flush, skid_full;
    logic [CW-1:0]          skid_count;
    logic                   credit_open;
    logic [SZ_W-1:0]        lim;

    logic [SZ_W-1:0]        p_size;
    logic [WIDTH-1:0]       p_sq, p_se;
    logic [WIDTH*DST_W-1:0] p_nd;

    logic [WIDTH-1:0]       sc_grant;
    logic [SZ_W-1:0]        sc_size, sc_off;
    logic [WIDTH*IDX_W-1:0] sc_src;
    logic                   sc_blocked, sc_barrier;
    logic                   in_nz;

    assign grp_in   = {dec_size, dec_squashed, dec_serial, dec_ndst};
    assign proc_grp = (r_q.state == RN_UNBLK) ? skid_head : grp_in;
    assign {p_size, p_sq, p_se, p_nd} = proc_grp;
    assign in_nz    = (dec_size != '0);

    rn_credit #(
        .WIDTH(WIDTH), .LAT(LAT), .CNT_W(CNT_W), .SZ_W(SZ_W)
    ) u_credit (
        .rob_free(rob_free), .iq_free(iq_free),
        .iew_stall(iew_stall), .cmt_stall(cmt_stall),
        .credit_open(credit_open), .lim(lim)
    );

    rn_slot_scan #(
        .WIDTH(WIDTH), .DST_W(DST_W), .CNT_W(CNT_W), .SZ_W(SZ_W), .IDX_W(IDX_W)
    ) u_scan (
        .grp_size(p_size), .start(r_q.off), .squashed(p_sq), .serial(p_se),
        .ndst(p_nd), .lim(lim), .preg_free(preg_free),
        .grant(sc_grant), .out_size(sc_size), .out_src(sc_src),
        .next_off(sc_off), .blocked(sc_blocked), .barrier(sc_barrier)
    );

    rn_skid #(
        .DEPTH(SKID_DEPTH), .DW(GW)
    ) u_skid (
        .clk(clk), .rst_n(rst_n), .flush(skid_flush), .push(skid_push),
        .pop(skid_pop), .din(grp_in), .dout(skid_head),
        .count(skid_count), .full(skid_full)
    );

    always_comb begin
        r_d        = r_q;
        r_d.grant  = '0;
        r_d.osize  = '0;
        r_d.osrc   = '0;
        skid_push  = 1'b0;
        skid_pop   = 1'b0;
        skid_flush = 1'b0;
        if (cmt_squash) begin
            r_d.state  = RN_SQUASH;
            r_d.off    = '0;
            r_d.stall  = 1'b0;
            skid_flush = 1'b1;
        end else begin
            unique case (r_q.state)
                RN_BLOCK: begin
                    skid_push = in_nz;
                    r_d.stall = 1'b1;
                    if (credit_open && preg_free != '0) r_d.state = RN_UNBLK;
                end
                RN_BARRIER: begin
                    skid_push = in_nz;
                    r_d.stall = 1'b1;
                end
                RN_UNBLK: begin
                    skid_push = in_nz;
                    r_d.grant = sc_grant;
                    r_d.osize = sc_size;
                    r_d.osrc  = sc_src;
                    if (sc_blocked) begin
                        r_d.state = sc_barrier ? RN_BARRIER : RN_BLOCK;
                        r_d.off   = sc_off;
                        r_d.stall = 1'b1;
                    end else begin
                        skid_pop = 1'b1;
                        r_d.off  = '0;
                        if (skid_count == CW'(1) && !in_nz) begin
                            r_d.state = RN_RUN;
                            r_d.stall = 1'b0;
                        end else begin
                            r_d.state = RN_UNBLK;
                            r_d.stall = 1'b1;
                        end
                    end
                end
                default: begin
                    if (in_nz) begin
                        r_d.grant = sc_grant;
                        r_d.osize = sc_size;
                        r_d.osrc  = sc_src;
                        if (sc_blocked) begin
                            skid_push = 1'b1;
                            r_d.state = sc_barrier ? RN_BARRIER : RN_BLOCK;
                            r_d.off   = sc_off;
                            r_d.stall = 1'b1;
                        end else begin
                            r_d.state = RN_RUN;
                            r_d.off   = '0;
                            r_d.stall = 1'b0;
                        end
                    end else begin
                        r_d.state = RN_IDLE;
                        r_d.stall = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= RN_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign grant        = r_q.grant;
    assign out_size     = r_q.osize;
    assign out_src      = r_q.osrc;
    assign decode_stall = r_q.stall;
    assign stage_state  = r_q.state;
endmodule

// File: rtl/rn_group_flow_chk.sv
module rn_group_flow_chk #(
    parameter int WIDTH = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cmt_squash,
    input logic                          iew_stall,
    input logic                          cmt_stall,
    input logic [2:0]                    stage_state,
    input logic [WIDTH-1:0]              grant,
    input logic [$clog2(WIDTH+1)-1:0]    out_size,
    input logic                          skid_push,
    input logic                          skid_full
);
    // R10: squash wins and leaves an empty output group
    p_squash_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |=> (stage_state == 3'd4 && grant == '0 && out_size == '0));

    // R7: output size agrees with the grant count
    p_pack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == int'(out_size));

    // R9: a blocked stage renames nothing on its next cycle
    p_blocked_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_state == 3'd2 && !cmt_squash) |=> out_size == '0);

    // R12/R9: a downstream stall keeps a blocked stage blocked
    p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_state == 3'd2 && (iew_stall || cmt_stall) && !cmt_squash) |=> stage_state == 3'd2);

    // R6: the barrier holds until a squash
    p_barrier_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_state == 3'd5 && !cmt_squash) |=> stage_state == 3'd5);

    // R8: parked groups never overflow the skid buffer
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(skid_push && skid_full && !cmt_squash));
endmodule

bind rn_group_flow rn_group_flow_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmt_squash(cmt_squash),
    .iew_stall(iew_stall), .cmt_stall(cmt_stall),
    .stage_state(stage_state), .grant(grant), .out_size(out_size),
    .skid_push(skid_push), .skid_full(skid_full)
);

// File: tb/rn_group_flow_test.sv
`timescale 1ns/1ps
module rn_group_flow_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dec_size = '0;
    logic [3:0] dec_squashed = '0, dec_serial = '0;
    logic [7:0] dec_ndst = '0;
    logic [5:0] rob_free = '0, iq_free = '0, preg_free = '0;
    logic       iew_stall = 1'b0, cmt_stall = 1'b0, cmt_squash = 1'b0;
    logic [3:0] grant;
    logic [2:0] out_size;
    logic [7:0] out_src;
    logic       decode_stall;
    logic [2:0] stage_state;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rn_group_flow uut (
        .clk(clk), .rst_n(rst_n), .dec_size(dec_size), .dec_squashed(dec_squashed),
        .dec_serial(dec_serial), .dec_ndst(dec_ndst), .rob_free(rob_free),
        .iq_free(iq_free), .preg_free(preg_free), .iew_stall(iew_stall),
        .cmt_stall(cmt_stall), .cmt_squash(cmt_squash), .grant(grant),
        .out_size(out_size), .out_src(out_src), .decode_stall(decode_stall),
        .stage_state(stage_state)
    );

    typedef struct {
        int         size;
        logic [3:0] sq;
        logic [3:0] se;
        logic [7:0] nd;
    } grp_t;

    // reference model state
    grp_t       skq[$];
    int         m_state = 0, m_off = 0;
    logic [3:0] e_grant = '0;
    int         e_size = 0;
    logic [7:0] e_src = '0;
    bit         e_stall = 0;

    function automatic void mscan(grp_t g, int start, int lim, int preg,
                                  output logic [3:0] gr, output int n,
                                  output logic [7:0] src, output int noff,
                                  output bit blk, output bit bar);
        int avail = g.size - start;
        int off = start;
        bit stop = 0;
        gr = '0; n = 0; src = '0; blk = 0; bar = 0;
        if (lim < avail) begin avail = lim; blk = 1; end
        for (int k = start; k < g.size; k++) begin
            if (!stop && avail > 0) begin
                if (g.sq[k]) begin off++; avail--; end
                else if (g.se[k]) begin bar = 1; blk = 1; stop = 1; end
                else if (preg < int'(g.nd[2*k +: 2])) begin blk = 1; stop = 1; end
                else begin
                    gr[k] = 1'b1; src[2*n +: 2] = 2'(k); n++;
                    preg -= int'(g.nd[2*k +: 2]); off++; avail--;
                end
            end
        end
        noff = blk ? off : 0;
    endfunction

    task automatic model_step();
        int r, q, m, lim, noff, n;
        bit open, blk, bar;
        logic [3:0] gr;
        logic [7:0] src;
        grp_t gin;
        gin.size = int'(dec_size); gin.sq = dec_squashed; gin.se = dec_serial; gin.nd = dec_ndst;
        r = int'(rob_free) - 8; q = int'(iq_free) - 8;
        m = (r < q) ? r : q;
        open = (m > 0) && !iew_stall && !cmt_stall;
        lim = !open ? 0 : (m > 4 ? 4 : m);
        e_grant = '0; e_size = 0; e_src = '0;
        if (cmt_squash) begin
            m_state = 4; m_off = 0; e_stall = 0; skq.delete();
        end else if (m_state == 2) begin
            if (gin.size != 0 && skq.size() < 2) skq.push_back(gin);
            e_stall = 1;
            if (open && preg_free != 0) m_state = 3;
        end else if (m_state == 5) begin
            if (gin.size != 0 && skq.size() < 2) skq.push_back(gin);
            e_stall = 1;
        end else if (m_state == 3) begin
            mscan(skq[0], m_off, lim, int'(preg_free), gr, n, src, noff, blk, bar);
            e_grant = gr; e_size = n; e_src = src;
            if (gin.size != 0 && skq.size() < 2) skq.push_back(gin);
            if (blk) begin
                m_state = bar ? 5 : 2; m_off = noff; e_stall = 1;
            end else begin
                void'(skq.pop_front()); m_off = 0;
                if (skq.size() == 0) begin m_state = 1; e_stall = 0; end
                else begin m_state = 3; e_stall = 1; end
            end
        end else begin
            if (gin.size != 0) begin
                mscan(gin, m_off, lim, int'(preg_free), gr, n, src, noff, blk, bar);
                e_grant = gr; e_size = n; e_src = src;
                if (blk) begin
                    skq.push_back(gin); m_state = bar ? 5 : 2; m_off = noff; e_stall = 1;
                end else begin
                    m_state = 1; m_off = 0; e_stall = 0;
                end
            end else begin
                m_state = 0; e_stall = 0;
            end
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "state", int'(stage_state), m_state);
        chk(tag, "stall", int'(decode_stall), int'(e_stall));
        chk(tag, "grant", int'(grant), int'(e_grant));
        chk(tag, "size", int'(out_size), e_size);
        chk(tag, "src", int'(out_src), int'(e_src));
    endtask

    // called at a falling edge with inputs already set
    task automatic cycle(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic set_grp(int sz, logic [3:0] sq, logic [3:0] se, logic [7:0] nd);
        dec_size = 3'(sz); dec_squashed = sq; dec_serial = se; dec_ndst = nd;
    endtask

    task automatic clear_all();
        set_grp(0, 4'h0, 4'h0, 8'h00);
        iew_stall = 0; cmt_stall = 0;
        cmt_squash = 1; cycle("R10");
        cmt_squash = 0;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "state", int'(stage_state), 0);
        chk("R1", "stall", int'(decode_stall), 0);
        chk("R1", "grant", int'(grant), 0);
        chk("R1", "size", int'(out_size), 0);

        // R2: credit derating to exactly zero blocks the whole group
        rob_free = 6'd8; iq_free = 6'd20; preg_free = 6'd20;
        set_grp(4, 4'h0, 4'h0, 8'h55);
        cycle("R2");
        chk("R2", "state_blocked", int'(stage_state), 2);
        chk("R11", "stall_blocked", int'(decode_stall), 1);
        // R9: downstream stall keeps it blocked
        set_grp(0, 4'h0, 4'h0, 8'h00);
        rob_free = 6'd20; iew_stall = 1;
        cycle("R9");
        chk("R9", "still_blocked", int'(stage_state), 2);
        iew_stall = 0;
        cycle("R9");
        chk("R9", "unblocking", int'(stage_state), 3);
        cycle("R8");
        chk("R8", "resume_grants_all", int'(grant), 4'hF);
        chk("R8", "back_running", int'(stage_state), 1);
        clear_all();

        // R3 and R8: credit of two against four pending slots, then resume at slot 2
        rob_free = 6'd10; iq_free = 6'd20; preg_free = 6'd20;
        set_grp(4, 4'h0, 4'h0, 8'h55);
        cycle("R3");
        chk("R3", "partial_grant", int'(grant), 4'h3);
        chk("R3", "blocked", int'(stage_state), 2);
        set_grp(0, 4'h0, 4'h0, 8'h00);
        rob_free = 6'd20;
        cycle("R9");
        cycle("R8");
        chk("R8", "resume_at_offset", int'(grant), 4'hC);
        chk("R7", "resume_src", int'(out_src), 8'h0E);
        clear_all();

        // R4 and R7: squashed slot 1 is skipped and packing closes the gap
        set_grp(4, 4'h2, 4'h0, 8'h55);
        cycle("R4");
        chk("R4", "skip_grant", int'(grant), 4'hD);
        chk("R7", "packed_src", int'(out_src), 8'h38);
        chk("R7", "packed_size", int'(out_size), 3);

        // R5: one free register, each slot needs one
        preg_free = 6'd1;
        set_grp(4, 4'h0, 4'h0, 8'h55);
        cycle("R5");
        chk("R5", "preg_stop", int'(grant), 4'h1);
        chk("R5", "blocked", int'(stage_state), 2);
        clear_all();

        // R6: serializing slot 2
        preg_free = 6'd20;
        set_grp(4, 4'h0, 4'h4, 8'h55);
        cycle("R6");
        chk("R6", "barrier_grant", int'(grant), 4'h3);
        chk("R6", "barrier_state", int'(stage_state), 5);
        set_grp(0, 4'h0, 4'h0, 8'h00);
        cycle("R6");
        chk("R6", "barrier_holds", int'(stage_state), 5);
        clear_all();
        chk("R10", "squash_state", int'(stage_state), 4);

        // R12: commit stall with a fresh group
        cmt_stall = 1;
        set_grp(3, 4'h0, 4'h0, 8'h15);
        cycle("R12");
        chk("R12", "no_grant", int'(grant), 0);
        chk("R12", "blocked", int'(stage_state), 2);
        clear_all();

        // random mix
        for (int i = 0; i < 3000; i++) begin
            if (!e_stall && ($urandom % 5) != 0) begin
                set_grp(1 + int'($urandom % 4),
                        4'(($urandom % 8 == 0) ? (1 << ($urandom % 4)) : 0),
                        4'(($urandom % 24 == 0) ? (1 << ($urandom % 4)) : 0),
                        8'($urandom));
            end else begin
                set_grp(0, 4'h0, 4'h0, 8'h00);
            end
            rob_free   = 6'(6 + $urandom % 12);
            iq_free    = 6'(8 + $urandom % 18);
            preg_free  = 6'($urandom % 10);
            iew_stall  = ($urandom % 10) == 0;
            cmt_stall  = ($urandom % 10) == 0;
            cmt_squash = ($urandom % 40) == 0;
            cycle("R7");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule